// File: doc/BRIEF.md
# Signed Arithmetic-Logic Unit with Overflow-Safe Compare

This block is a purely combinational 32-bit arithmetic-logic unit. A one-bit operand-inversion control and a two-bit function select choose between bitwise AND, bitwise OR, two's-complement addition, subtraction and a signed less-than compare. Along with the 32-bit result, it reports a zero flag and a signed-overflow flag. It sits in the execute stage of a simple processor datapath, where a separate decoder drives its three control bits.

Subtraction reuses the adder. Operand B is inverted and a carry of one enters bit 0. Overflow is found by comparing the carry that enters the sign position with the carry that leaves it. The compare takes the sign of A − B and flips it when that subtraction overflowed, so the answer stays correct at the extremes of the signed range. The block holds no state, so it has no clock or reset. The design is split into a control decoder, a bitwise unit and a ripple adder, and the top level selects among their outputs. The decoder names four function classes: FN_AND, FN_OR, FN_SUM and FN_SLT. There are no transitions between them; each cycle is decoded on its own.

Top module: `sign_safe_alu`

## Requirements
- R1: Control {b_negate, op_sel} = 0_00 gives result = opnd_a AND opnd_b.
- R2: Control 0_01 gives result = opnd_a OR opnd_b.
- R3: Control 0_10 gives result = (opnd_a + opnd_b) modulo 2^32.
- R4: Control 1_10 gives result = (opnd_a − opnd_b) modulo 2^32. This is formed as opnd_a + NOT opnd_b + 1.
- R5: For add, subtract and compare, overflow is 1 exactly when the carry into bit 31 differs from the carry out of bit 31. Equivalently, overflow is 1 when two operands of the same effective sign give a sum of the other sign.
- R6: Adding operands of opposite sign never overflows. Subtracting operands of the same sign never overflows.
- R7: Control 1_11 gives result bit 0 = 1 when opnd_a < opnd_b as signed 32-bit values, and bits 31:1 = 0. This holds even when A − B overflows, for example 0x80000000 against 0x7FFFFFFF and the reverse.
- R8: Overflow is 0 for controls 0_00 and 0_01.
- R9: zero is 1 exactly when all 32 bits of the final result are 0. This applies to every function, including the compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| b_negate | input | 1 | Invert operand B and inject carry-in of 1 |
| op_sel | input | 2 | Function select: 00 AND, 01 OR, 10 sum, 11 compare |
| result | output | 32 | Function result |
| zero | output | 1 | All result bits are 0 |
| overflow | output | 1 | Signed overflow of the adder path |

## Verification
Two functions can act on the same operands at once: the signed compare and the overflow detector. Subtraction overflow is exactly the case in which the raw sign is wrong. The bench drives the compare with operand pairs at opposite ends of the signed range: the most-negative value against the most-positive value, and the reverse. It then judges both outputs in the same sample. Bit 0 must follow the true signed order while overflow is 1, and the zero flag must agree with the compare result.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [1:0] {
        FN_AND = 2'b00,
        FN_OR  = 2'b01,
        FN_SUM = 2'b10,
        FN_SLT = 2'b11
    } alu_fn_e;
endpackage

// File: rtl/alu_fn_decode.sv
module alu_fn_decode
    import alu_pkg::*;
(
    input  logic [1:0] op_sel,
    output alu_fn_e    fn
);
    always_comb begin
        unique case (op_sel)
            2'b00:   fn = FN_AND;
            2'b01:   fn = FN_OR;
            2'b10:   fn = FN_SUM;
            default: fn = FN_SLT;
        endcase
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_fn_e          fn,
    output logic [WIDTH-1:0] y
);
    always_comb begin
        if (fn == FN_OR) y = a | b;
        else             y = a & b;
    end
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] carry;
    assign carry[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end

    assign ovf = carry[MSB] ^ carry[WIDTH];

    // Sign-based rule must agree with the carry-based detector
    always_comb begin
        p_ovf_sign_rule_r5: assert (ovf == ((a[MSB] == b[MSB]) && (sum[MSB] != a[MSB])))
            else $error("R5 overflow disagrees with sign rule");
        if (a[MSB] != b[MSB])
            p_no_overflow_r6: assert (!ovf)
                else $error("R6 overflow with opposite effective signs");
    end
endmodule

// File: rtl/sign_safe_alu.sv
module sign_safe_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [31:0] opnd_a,
    input  logic [31:0] opnd_b,
    input  logic        b_negate,
    input  logic [1:0]  op_sel,
    output logic [31:0] result,
    output logic        zero,
    output logic        overflow
);
    localparam int MSB = WIDTH - 1;

    alu_fn_e          fn;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] sum_y;
    logic             add_ovf;
    logic             lt_bit;

    assign b_eff = b_negate ? ~opnd_b : opnd_b;

    alu_fn_decode u_decode (
        .op_sel (op_sel),
        .fn     (fn)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a  (opnd_a),
        .b  (b_eff),
        .fn (fn),
        .y  (logic_y)
    );

    alu_ripple_adder #(.WIDTH(WIDTH)) u_adder (
        .a   (opnd_a),
        .b   (b_eff),
        .cin (b_negate),
        .sum (sum_y),
        .ovf (add_ovf)
    );

    // Raw sign is wrong exactly when the subtraction overflowed
    assign lt_bit = sum_y[MSB] ^ add_ovf;

    always_comb begin
        unique case (fn)
            FN_AND, FN_OR: begin
                result   = logic_y;
                overflow = 1'b0;
            end
            FN_SUM: begin
                result   = sum_y;
                overflow = add_ovf;
            end
            default: begin
                result   = {{(WIDTH-1){1'b0}}, lt_bit};
                overflow = add_ovf;
            end
        endcase
    end

    assign zero = ~|result;

    always_comb begin
        if (fn == FN_SLT)
            p_slt_upper_clear_r7: assert (result[MSB:1] == '0)
                else $error("R7 compare upper bits not clear");
        if (!op_sel[1])
            p_logic_no_overflow_r8: assert (!overflow)
                else $error("R8 overflow on bitwise op");
        if (fn == FN_SLT && b_negate)
            p_slt_zero_r9: assert (zero == !($signed(opnd_a) < $signed(opnd_b)))
                else $error("R9 zero flag disagrees with compare");
    end
endmodule

// File: tb/test_sign_safe_alu.sv
`timescale 1ns/1ps
module test_sign_safe_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        b_negate = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [31:0] result;
    logic        zero;
    logic        overflow;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    sign_safe_alu i_sign_safe_alu (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .b_negate(b_negate), .op_sel(op_sel),
        .result(result), .zero(zero), .overflow(overflow)
    );

    task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic bn, input logic [1:0] op);
        logic [31:0] exp_r;
        logic        exp_v;
        @(posedge clk);
        opnd_a = a; opnd_b = b; b_negate = bn; op_sel = op;
        case ({bn, op})
            3'b000: begin exp_r = a & b; exp_v = 1'b0; end
            3'b001: begin exp_r = a | b; exp_v = 1'b0; end
            3'b010: begin exp_r = a + b;
                          exp_v = (a[31] == b[31]) && (exp_r[31] != a[31]); end
            3'b110: begin exp_r = a - b;
                          exp_v = (a[31] != b[31]) && (exp_r[31] != a[31]); end
            default: begin exp_r = {31'b0, ($signed(a) < $signed(b))};
                          exp_v = (a[31] != b[31]) && (((a - b) >> 31) != {31'b0, a[31]}); end
        endcase
        @(negedge clk);
        checks++;
        if (result !== exp_r || overflow !== exp_v || zero !== (exp_r == 0)) begin
            errors++;
            $display("FAIL %s a=%h b=%h ctl=%b: got r=%h v=%b z=%b exp r=%h v=%b z=%b",
                     tag, a, b, {bn, op}, result, overflow, zero, exp_r, exp_v, exp_r == 0);
        end
    endtask

    task automatic t_idle();          // R9: quiet inputs give zero result
        run_op("R9", 32'h0, 32'h0, 1'b0, 2'b00);
    endtask
    task automatic t_bitwise();
        run_op("R1", 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 2'b00);
        run_op("R2", 32'hF0F0_1234, 32'h0FF0_FF00, 1'b0, 2'b01);
        run_op("R8", 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 2'b01);
    endtask
    task automatic t_add();
        run_op("R3", 32'd1234, 32'd4321, 1'b0, 2'b10);
        run_op("R3", 32'hFFFF_FFFF, 32'h1, 1'b0, 2'b10);
        run_op("R5", 32'h7FFF_FFFF, 32'h1, 1'b0, 2'b10);
        run_op("R5", 32'h8000_0000, 32'h8000_0000, 1'b0, 2'b10);
        run_op("R6", 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 2'b10);
    endtask
    task automatic t_sub();
        run_op("R4", 32'd10, 32'd25, 1'b1, 2'b10);
        run_op("R4", 32'h1234_5678, 32'h1234_5678, 1'b1, 2'b10);
        run_op("R5", 32'h8000_0000, 32'h1, 1'b1, 2'b10);
        run_op("R5", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 2'b10);
        run_op("R6", 32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 2'b10);
    endtask
    task automatic t_slt();
        run_op("R7", 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, 2'b11);
        run_op("R7", 32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 2'b11);
        run_op("R7", 32'hFFFF_FFFF, 32'h1, 1'b1, 2'b11);
        run_op("R7", 32'd5, 32'd3, 1'b1, 2'b11);
        run_op("R9", 32'd7, 32'd7, 1'b1, 2'b11);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_bitwise();
        t_add();
        t_sub();
        t_slt();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule